// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that runs from its own slow clock and asserts a system-reset output when software fails to refresh it in time. Software reaches it through a small register bus in a separate bus clock domain. A single key register carries command words. One word starts the watchdog, one refreshes the counter, and one opens write access to the divider and reload registers. Once the watchdog runs, nothing short of the block's reset input stops it. A strap input can also start it automatically when reset is released.

Every configuration value and command crosses into the slow domain through its own toggle handshake. While a divider or reload value is in transit, a busy flag in the status register stays set. Each expiry raises a sticky cause flag on the bus side, which software clears by writing to the status register.

Register map (two address bits): 0 = key (reads 0), 1 = divider code (bits 2:0), 2 = reload value (bits CNT_W-1:0), 3 = status. Status bits: 0 = divider update busy, 1 = reload update busy, 2 = running, 3 = expiry cause (sticky).

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the divider code reads 0, the reload register reads all ones, status reads 0 (unless the strap is set, see R5) and wd_reset_o is low.
- R2: Writes to the divider (address 1) and reload (address 2) registers change nothing unless the unlock key 0x5555 was the last value written to the key register.
- R3: Writing any key value other than 0x5555 (including refresh 0xAAAA and start 0xCCCC) removes write access. Later divider and reload writes are then ignored.
- R4: Writing 0xCCCC to the key register starts the watchdog and sets status bit 2. Before that, wd_reset_o never rises. With the reset-time divider (code 0) the counter starts from all ones, so the first expiry comes 2^CNT_W x 4 slow cycles after the start command, plus synchronizer latency of one to five slow cycles.
- R5: If hw_start_i is high when reset is released, the watchdog runs without any key write, status bit 2 reads 1, and the first expiry follows about 2^CNT_W x 4 slow cycles later.
- R6: Once running, no key value and no register write stops the watchdog. Status bit 2 stays 1 until rst_ni is asserted.
- R7: Writing 0xAAAA loads the counter with the reload value and restarts the divider. Expiry follows (reload+1) x divisor slow cycles later, plus one to five cycles of latency. Refreshing more often than that keeps wd_reset_o low.
- R8: Divider code c in 0..5 selects a divisor of 4 x 2^c. Codes 6 and 7 both select 256.
- R9: An accepted divider or reload write sets status bit 0 or bit 1 respectively in the next bus cycle. The bit clears once the slow domain acknowledges. A write to a register whose busy bit is set is ignored.
- R10: Expiry occurs on a divider tick while the counter is zero. wd_reset_o is then high for exactly RST_CYC slow cycles, and the counter reloads and keeps counting, so free-running expiries recur every (reload+1) x divisor cycles.
- R11: Every expiry sets status bit 3. The bit stays set until the bus writes a 1 to bit 3 of the status register. Writing 0 to that bit leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk_i | input | 1 | Register bus clock |
| wd_clk_i | input | 1 | Slow watchdog counter clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| hw_start_i | input | 1 | Strap sampled after reset; high starts the watchdog |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register |
| wd_reset_o | output | 1 | System reset request pulse |

## Verification
The bench builds the block with CNT_W = 8 and RST_CYC = 6. The narrow counter shortens the reset-time timeout to 1024 slow cycles, so the start-key, strap-start and free-running reload paths can all run to expiry. The six-cycle pulse makes the width check distinct from the default. Random divider codes and reload values are paired so that every expected timeout lies between a few dozen and about 1300 slow cycles. At that scale a wrong divisor or an off-by-one reload misses the measurement window.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 2;
    localparam int PCODE_W   = 3;
    localparam int PDIV_MIN  = 4;
    localparam int PCODE_MAX = 6;
    localparam int PDIV_W    = $clog2(PDIV_MIN) + PCODE_MAX;

    localparam logic [DATA_W-1:0] KEY_UNLOCK = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_KICK   = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_START  = 16'hCCCC;

    // bus -> slow domain toggles
    localparam int REQ_N     = 4;
    localparam int REQ_PRE   = 0;
    localparam int REQ_RLD   = 1;
    localparam int REQ_START = 2;
    localparam int REQ_KICK  = 3;

    // slow -> bus domain toggles
    localparam int ACK_N   = 3;
    localparam int ACK_PRE = 0;
    localparam int ACK_RLD = 1;
    localparam int ACK_EXP = 2;

    localparam int ST_PBUSY = 0;
    localparam int ST_RBUSY = 1;
    localparam int ST_RUN   = 2;
    localparam int ST_CAUSE = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_KEY    = 2'd0,
        A_PRESC  = 2'd1,
        A_RELOAD = 2'd2,
        A_STATUS = 2'd3
    } wdg_addr_e;

    // terminal value of the divider counter: divisor - 1
    function automatic logic [PDIV_W-1:0] presc_last(input logic [PCODE_W-1:0] code);
        logic [PDIV_W:0]    div;
        logic [PCODE_W-1:0] sh;
        sh  = (code > PCODE_W'(PCODE_MAX)) ? PCODE_W'(PCODE_MAX) : code;
        div = (PDIV_W+1)'(PDIV_MIN) << sh;
        div = div - (PDIV_W+1)'(1);
        return div[PDIV_W-1:0];
    endfunction

endpackage

// File: rtl/wdg_sync_bit.sv
module wdg_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/wdg_bus_side.sv
module wdg_bus_side
    import wdg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               strap_i,
    input  logic               sel_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [PCODE_W-1:0] pcode_o,
    output logic [CNT_W-1:0]   reload_o,
    output logic [REQ_N-1:0]   req_tgl_o,
    input  logic [ACK_N-1:0]   ack_i
);

    typedef struct packed {
        logic               unlock;
        logic               strap_done;
        logic               run;
        logic               cause;
        logic               exp_seen;
        logic [REQ_N-1:0]   tgl;
        logic [PCODE_W-1:0] pcode;
        logic [CNT_W-1:0]   reload;
    } bus_state_t;

    bus_state_t s_d, s_q;
    logic wr_key, wr_pre, wr_rld, wr_st;
    logic pbusy, rbusy;

    always_comb begin
        wr_key = sel_i && wr_i && (wdg_addr_e'(addr_i) == A_KEY);
        wr_pre = sel_i && wr_i && (wdg_addr_e'(addr_i) == A_PRESC);
        wr_rld = sel_i && wr_i && (wdg_addr_e'(addr_i) == A_RELOAD);
        wr_st  = sel_i && wr_i && (wdg_addr_e'(addr_i) == A_STATUS);
        pbusy  = s_q.tgl[REQ_PRE] ^ ack_i[ACK_PRE];
        rbusy  = s_q.tgl[REQ_RLD] ^ ack_i[ACK_RLD];

        s_d = s_q;

        if (!s_q.strap_done) begin
            s_d.strap_done = 1'b1;
            if (strap_i) s_d.run = 1'b1;
        end

        if (wr_key) begin
            s_d.unlock = (wdata_i == KEY_UNLOCK);
            if (wdata_i == KEY_KICK) s_d.tgl[REQ_KICK] = ~s_q.tgl[REQ_KICK];
            if (wdata_i == KEY_START) begin
                s_d.tgl[REQ_START] = ~s_q.tgl[REQ_START];
                s_d.run            = 1'b1;
            end
        end

        if (wr_pre && s_q.unlock && !pbusy) begin
            s_d.pcode        = wdata_i[PCODE_W-1:0];
            s_d.tgl[REQ_PRE] = ~s_q.tgl[REQ_PRE];
        end

        if (wr_rld && s_q.unlock && !rbusy) begin
            s_d.reload       = wdata_i[CNT_W-1:0];
            s_d.tgl[REQ_RLD] = ~s_q.tgl[REQ_RLD];
        end

        s_d.exp_seen = ack_i[ACK_EXP];
        if (wr_st && wdata_i[ST_CAUSE]) s_d.cause = 1'b0;
        if (ack_i[ACK_EXP] != s_q.exp_seen) s_d.cause = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q        <= '0;
            s_q.reload <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (wdg_addr_e'(addr_i))
            A_PRESC:  rdata_o[PCODE_W-1:0] = s_q.pcode;
            A_RELOAD: rdata_o[CNT_W-1:0]   = s_q.reload;
            A_STATUS: begin
                rdata_o[ST_PBUSY] = pbusy;
                rdata_o[ST_RBUSY] = rbusy;
                rdata_o[ST_RUN]   = s_q.run;
                rdata_o[ST_CAUSE] = s_q.cause;
            end
            default: ;
        endcase
    end

    assign pcode_o   = s_q.pcode;
    assign reload_o  = s_q.reload;
    assign req_tgl_o = s_q.tgl;

    // R2: a locked divider write leaves the register unchanged
    assert_locked_presc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_pre && !s_q.unlock) |=> $stable(s_q.pcode))
        else $error("locked divider write changed value");

    // R3: any key other than unlock closes write access
    assert_relock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_key && (wdata_i != KEY_UNLOCK)) |=> !s_q.unlock)
        else $error("write access still open after non-unlock key");

    // R9: an accepted reload write is reported busy in the next cycle
    assert_busy_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_rld && s_q.unlock && !rbusy) |=> rbusy)
        else $error("reload busy not raised");

    // R6: the running bit never drops while out of reset
    assert_run_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.run |=> s_q.run)
        else $error("running bit dropped");

    // R11: the cause flag holds unless cleared by a write of one
    assert_cause_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.cause && !(wr_st && wdata_i[ST_CAUSE])) |=> s_q.cause)
        else $error("cause flag lost");

endmodule

// File: rtl/wdg_wd_side.sv
module wdg_wd_side
    import wdg_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int RST_CYC = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               strap_i,
    input  logic [PCODE_W-1:0] pcode_i,
    input  logic [CNT_W-1:0]   reload_i,
    input  logic [REQ_N-1:0]   req_i,
    output logic [ACK_N-1:0]   ack_o,
    output logic               wd_rst_o
);

    localparam int PULSE_W = $clog2(RST_CYC + 1);

    typedef struct packed {
        logic               run;
        logic               strap_done;
        logic               etgl;
        logic [REQ_N-1:0]   seen;
        logic [PCODE_W-1:0] pcode;
        logic [CNT_W-1:0]   reload;
        logic [PDIV_W-1:0]  pcnt;
        logic [CNT_W-1:0]   cnt;
        logic [PULSE_W-1:0] pulse;
    } wd_state_t;

    wd_state_t s_d, s_q;
    logic start_ev, kick_ev, tick;

    always_comb begin
        start_ev = req_i[REQ_START] != s_q.seen[REQ_START];
        kick_ev  = req_i[REQ_KICK]  != s_q.seen[REQ_KICK];
        tick     = s_q.run && (s_q.pcnt >= presc_last(s_q.pcode));

        s_d      = s_q;
        s_d.seen = req_i;

        if (req_i[REQ_PRE] != s_q.seen[REQ_PRE]) s_d.pcode  = pcode_i;
        if (req_i[REQ_RLD] != s_q.seen[REQ_RLD]) s_d.reload = reload_i;

        if (!s_q.strap_done) begin
            s_d.strap_done = 1'b1;
            if (strap_i) s_d.run = 1'b1;
        end

        if (s_q.pulse != '0) s_d.pulse = s_q.pulse - PULSE_W'(1);

        if (s_q.run) s_d.pcnt = tick ? '0 : s_q.pcnt + PDIV_W'(1);

        if (tick) begin
            if (s_q.cnt == '0) begin
                s_d.cnt   = s_q.reload;
                s_d.pulse = PULSE_W'(RST_CYC);
                s_d.etgl  = ~s_q.etgl;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end

        if (start_ev && !s_q.run) begin
            s_d.run  = 1'b1;
            s_d.pcnt = '0;
        end

        if (kick_ev) begin
            s_d.cnt  = s_q.reload;
            s_d.pcnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q        <= '0;
            s_q.cnt    <= '1;
            s_q.reload <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ack_o          = '0;
        ack_o[ACK_PRE] = s_q.seen[REQ_PRE];
        ack_o[ACK_RLD] = s_q.seen[REQ_RLD];
        ack_o[ACK_EXP] = s_q.etgl;
    end

    assign wd_rst_o = (s_q.pulse != '0);

    // R6: the slow-domain run state never clears
    assert_run_sticky_wd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.run |=> s_q.run)
        else $error("watchdog stopped");

    // R4: no reset request before the watchdog runs
    assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_q.run |-> !wd_rst_o)
        else $error("reset request while idle");

    // R10: the reset pulse lasts more than one cycle
    assert_pulse_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wd_rst_o) |=> wd_rst_o)
        else $error("reset pulse too short");

    // R10: each expiry toggles the cause event toward the bus side
    assert_expiry_event_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wd_rst_o) |-> (s_q.etgl != $past(s_q.etgl)))
        else $error("expiry event not signalled");

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int RST_CYC     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk_i,
    input  logic              wd_clk_i,
    input  logic              rst_ni,
    input  logic              hw_start_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              wd_reset_o
);

    logic [PCODE_W-1:0] pcode;
    logic [CNT_W-1:0]   reload;
    logic [REQ_N-1:0]   req_bus, req_wd;
    logic [ACK_N-1:0]   ack_wd, ack_bus;

    wdg_bus_side #(.CNT_W(CNT_W)) u_bus (
        .clk_i     (bus_clk_i),
        .rst_ni    (rst_ni),
        .strap_i   (hw_start_i),
        .sel_i     (bus_sel_i),
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .rdata_o   (bus_rdata_o),
        .pcode_o   (pcode),
        .reload_o  (reload),
        .req_tgl_o (req_bus),
        .ack_i     (ack_bus)
    );

    for (genvar i = 0; i < REQ_N; i++) begin : g_req_sync
        wdg_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (wd_clk_i),
            .rst_ni (rst_ni),
            .d_i    (req_bus[i]),
            .q_o    (req_wd[i])
        );
    end

    for (genvar j = 0; j < ACK_N; j++) begin : g_ack_sync
        wdg_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (bus_clk_i),
            .rst_ni (rst_ni),
            .d_i    (ack_wd[j]),
            .q_o    (ack_bus[j])
        );
    end

    wdg_wd_side #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_wd (
        .clk_i    (wd_clk_i),
        .rst_ni   (rst_ni),
        .strap_i  (hw_start_i),
        .pcode_i  (pcode),
        .reload_i (reload),
        .req_i    (req_wd),
        .ack_o    (ack_wd),
        .wd_rst_o (wd_reset_o)
    );

endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_PERIOD  = 3 * CLK_PERIOD;
    localparam int CNT_W      = 8;
    localparam int RST_CYC    = 6;
    localparam int LIMIT      = 190000;

    logic        bus_clk = 1'b0;
    logic        wd_clk  = 1'b0;
    logic        rst_n   = 1'b0;
    logic        strap   = 1'b0;
    logic        sel     = 1'b0;
    logic        wr      = 1'b0;
    logic [1:0]  addr    = '0;
    logic [15:0] wdata   = '0;
    logic [15:0] rdata;
    logic        wd_rst;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
    always #(WD_PERIOD/2)  wd_clk  = ~wd_clk;

    keyed_watchdog #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) uut (
        .bus_clk_i   (bus_clk),
        .wd_clk_i    (wd_clk),
        .rst_ni      (rst_n),
        .hw_start_i  (strap),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .wd_reset_o  (wd_rst)
    );

    function automatic int div_of(int code);
        return 4 << ((code > 6) ? 6 : code);
    endfunction

    function automatic int timeout_of(int code, int rel);
        return (rel + 1) * div_of(code);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge bus_clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge bus_clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge bus_clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [15:0] st;
        int n = 0;
        bus_read(2'd3, st);
        while ((st[1:0] != 2'b00) && (n < 80)) begin
            bus_read(2'd3, st);
            n++;
        end
        check(st[1:0] == 2'b00, req, int'(st[1:0]), 0);
    endtask

    task automatic wait_rise(input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(negedge wd_clk);
            n++;
            if (wd_rst) break;
        end
    endtask

    task automatic high_len(output int n);
        n = 1;
        while (n < 100) begin
            @(negedge wd_clk);
            if (!wd_rst) break;
            n++;
        end
    endtask

    task automatic quiet_low();
        while (wd_rst) @(negedge wd_clk);
        repeat (4) @(negedge wd_clk);
    endtask

    task automatic trial(input int code, input int rel);
        int e, d, w;
        logic [15:0] v;
        bus_write(2'd0, 16'h5555);
        bus_write(2'd1, 16'(code));
        wait_idle("R9");
        bus_write(2'd2, 16'(rel));
        wait_idle("R9");
        bus_read(2'd1, v);
        check(v == 16'(code), "R2", int'(v), code);
        bus_write(2'd0, 16'hAAAA);
        quiet_low();
        bus_write(2'd0, 16'hAAAA);
        e = timeout_of(code, rel);
        wait_rise(e + 50, d);
        check((d >= e + 1) && (d <= e + 5), "R7/R8 timeout", d, e);
        high_len(w);
        check(w == RST_CYC, "R10 pulse", w, RST_CYC);
    endtask

    initial begin : watchdog
        repeat (LIMIT) @(posedge bus_clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", LIMIT, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        int d, w, seen_hi;
        void'($urandom(32'd4711));

        repeat (5) @(negedge bus_clk);
        rst_n = 1'b1;
        repeat (3) @(negedge bus_clk);

        // R1: reset state
        bus_read(2'd1, v); check(v == 16'h0,  "R1 divider",  int'(v), 0);
        bus_read(2'd2, v); check(v == 16'hFF, "R1 reload",   int'(v), 255);
        bus_read(2'd3, v); check(v == 16'h0,  "R1 status",   int'(v), 0);
        check(wd_rst == 1'b0, "R1 reset out", int'(wd_rst), 0);

        // R2: locked writes ignored
        bus_write(2'd1, 16'd3);
        bus_read(2'd1, v); check(v == 16'h0, "R2 locked divider", int'(v), 0);
        bus_write(2'd2, 16'h20);
        bus_read(2'd2, v); check(v == 16'hFF, "R2 locked reload", int'(v), 255);

        // R4: idle before start
        seen_hi = 0;
        repeat (1500) begin
            @(negedge wd_clk);
            if (wd_rst) seen_hi++;
        end
        check(seen_hi == 0, "R4 idle", seen_hi, 0);

        // R4: start key, default timeout
        bus_write(2'd0, 16'hCCCC);
        bus_read(2'd3, v); check(v[2] == 1'b1, "R4 running", int'(v[2]), 1);
        wait_rise(2000, d);
        check((d >= 1025) && (d <= 1029), "R4 first expiry", d, 1024);

        // R10: pulse width and free-running period
        high_len(w);
        check(w == RST_CYC, "R10 pulse", w, RST_CYC);
        wait_rise(2000, d);
        check(d + w == 1024, "R10 period", d + w, 1024);
        high_len(w);

        // R11: sticky cause flag
        repeat (20) @(negedge bus_clk);
        bus_read(2'd3, v); check(v[3] == 1'b1, "R11 set", int'(v[3]), 1);
        bus_write(2'd3, 16'h0007);
        bus_read(2'd3, v); check(v[3] == 1'b1, "R11 hold", int'(v[3]), 1);
        bus_write(2'd3, 16'h0008);
        bus_read(2'd3, v); check(v[3] == 1'b0, "R11 clear", int'(v[3]), 0);

        // R9: busy flag and write while busy
        bus_write(2'd0, 16'h5555);
        bus_write(2'd2, 16'h30);
        bus_read(2'd3, v); check(v[1] == 1'b1, "R9 reload busy", int'(v[1]), 1);
        bus_write(2'd2, 16'h31);
        bus_read(2'd2, v); check(v == 16'h30, "R9 busy write ignored", int'(v), 48);
        wait_idle("R9 clear");
        bus_write(2'd1, 16'd2);
        bus_read(2'd3, v); check(v[0] == 1'b1, "R9 divider busy", int'(v[0]), 1);
        wait_idle("R9 clear");

        // R3: relocking keys
        bus_write(2'd0, 16'h1234);
        bus_write(2'd1, 16'd5);
        bus_read(2'd1, v); check(v == 16'd2, "R3 other key", int'(v), 2);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd0, 16'hAAAA);
        bus_write(2'd1, 16'd5);
        bus_read(2'd1, v); check(v == 16'd2, "R3 refresh key", int'(v), 2);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd0, 16'hCCCC);
        bus_write(2'd2, 16'h11);
        bus_read(2'd2, v); check(v == 16'h30, "R3 start key", int'(v), 48);

        // R6: no key stops it
        bus_write(2'd0, 16'h0000);
        bus_write(2'd0, 16'hFFFF);
        bus_write(2'd0, 16'(($urandom % 16'hFFFF) | 16'h0001));
        bus_read(2'd3, v); check(v[2] == 1'b1, "R6 still running", int'(v[2]), 1);

        // R8: codes 6 and 7 map to 256
        trial(6, 0);
        trial(7, 1);

        // R7/R8: random configurations
        for (int t = 0; t < 10; t++) begin
            int c, r;
            c = int'($urandom % 6);
            r = 8 + int'($urandom % (64 >> c));
            trial(c, r);
        end

        // R7: regular refresh prevents expiry
        bus_write(2'd0, 16'h5555);
        bus_write(2'd1, 16'd0);
        wait_idle("R9");
        bus_write(2'd2, 16'd63);
        wait_idle("R9");
        bus_write(2'd0, 16'hAAAA);
        quiet_low();
        seen_hi = 0;
        for (int k = 0; k < 10; k++) begin
            bus_write(2'd0, 16'hAAAA);
            repeat (100) begin
                @(negedge wd_clk);
                if (wd_rst) seen_hi++;
            end
        end
        check(seen_hi == 0, "R7 refresh keeps alive", seen_hi, 0);
        bus_read(2'd3, v); check(v[2] == 1'b1, "R6 running after refreshes", int'(v[2]), 1);

        // R5: strap start after reset
        @(negedge bus_clk);
        rst_n = 1'b0;
        strap = 1'b1;
        repeat (4) @(negedge bus_clk);
        rst_n = 1'b1;
        wait_rise(2000, d);
        check((d >= 1022) && (d <= 1030), "R5 strap expiry", d, 1025);
        bus_read(2'd3, v); check(v[2] == 1'b1, "R5 running", int'(v[2]), 1);
        bus_read(2'd2, v); check(v == 16'hFF, "R1 reload after reset", int'(v), 255);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule